// File: doc/BRIEF.md
# Dual Performance Event Counter

This unit holds two 20-bit event counters for hardware performance monitoring. Each counter adds the increment strobe that arrives on its own event input in every cycle. Counter 0 takes 0 to 15 events per cycle and counter 1 takes 0 to 3. Software sets the unit up through a small register-write port. It loads a start value into each counter, turns on the global counting gates, enables each counter on its own, and sets a per-counter interrupt mask.

When a counter carries out of its top bit, it keeps the wrapped low bits. If that counter's mask bit is set, its pending flag is latched, and the interrupt output follows the OR of the pending flags. Software reads both counters at once on a combined read port and clears pending flags by writing ones to them. It can reload a counter at any time to set how far away the next overflow is. A start value above a counter's legal ceiling is clamped down to that ceiling. This keeps a fresh preload from wrapping on its first increment.

Top module: `perf_ctr_pair`

## Requirements
- R1: After reset both counters read 0, both pending flags are 0, `irq` is 0 and every control field is 0.
- R2: A counter adds its event input in a cycle only when three conditions hold: its counter-enable bit is set, the mode bit is 0, and the system-wide enable or the per-process enable is 1. Otherwise it holds its value.
- R3: A write to address 0 loads the control fields from `reg_wdata`: bit 0 is the system-wide enable, bit 1 the per-process enable, bits 3:2 the counter enables (bit 2 for counter 0), bits 5:4 the interrupt mask (bit 4 for counter 0) and bit 6 the mode bit. The new fields act from the next cycle.
- R4: A write to address 1 preloads counter 0 and a write to address 2 preloads counter 1. A value above 0xFFFF0 (counter 0) or above 0xFFFFC (counter 1) is stored as that ceiling, and a value within range is stored unchanged.
- R5: When a preload write and an event increment reach the same counter in the same cycle, the preload wins and the events are dropped.
- R6: An increment that carries out of bit 19 counts as an overflow, and the counter keeps the low 20 bits of the sum.
- R7: An overflow sets the counter's pending flag only when that counter's mask bit is 1. `irq` is 1 exactly when at least one pending flag is 1.
- R8: A write to address 3 clears each pending flag whose `reg_wdata` bit is 1 (bit 0 for counter 0). If an overflow sets a flag in the same cycle it is cleared, the flag stays set.
- R9: With the mode bit at 1 (the unimplemented sampling mode), neither counter advances.
- R10: `rd_ctrs` shows counter 1 in bits 39:20 and counter 0 in bits 19:0, taken from the registered counter values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 control, 1 preload 0, 2 preload 1, 3 pending clear) |
| reg_wdata | input | 20 | Write data |
| evt0_inc | input | 4 | Event count for counter 0 this cycle |
| evt1_inc | input | 2 | Event count for counter 1 this cycle |
| rd_ctrs | output | 40 | Combined counter readback {counter 1, counter 0} |
| pend | output | 2 | Latched overflow pending flags |
| irq | output | 1 | Overflow interrupt request |

## Verification
Two pairs of events can land in the same cycle. A preload write can meet an event increment on the same counter, and a pending-flag clear can meet a fresh overflow. The bench sets up the first pair by writing a preload while driving a nonzero event count. The counter must show the clamped preload alone. For the second pair it walks counter 0 to 0xFFFFF and then, in one cycle, writes ones to both pending bits while driving an increment that wraps the counter. The other flag must drop, counter 0's flag must stay set, and the counter must hold the wrapped low bits.

// File: rtl/pcnt_pkg.sv
package pcnt_pkg;
  localparam int unsigned CW = 20;
  typedef logic [CW-1:0] cnt_t;

  typedef enum logic [1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_PRE0 = 2'd1,
    ADDR_PRE1 = 2'd2,
    ADDR_PCLR = 2'd3
  } addr_e;

  // bit 6 mode, 5:4 irq mask, 3:2 counter enables, 1 per-process, 0 system
  typedef struct packed {
    logic       mode_prof;
    logic [1:0] irq_en;
    logic [1:0] cnt_en;
    logic       proc_en;
    logic       sys_en;
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);

  function automatic cnt_t clamp_val(cnt_t v, cnt_t lim);
    return (v > lim) ? lim : v;
  endfunction

  function automatic logic [CW:0] add_wide(cnt_t a, cnt_t b);
    return {1'b0, a} + {1'b0, b};
  endfunction
endpackage

// File: rtl/pcnt_ctrl.sv
module pcnt_ctrl
  import pcnt_pkg::*;
#(
  parameter int unsigned NCTR = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr,
  input  logic [1:0]      reg_addr,
  input  cnt_t            reg_wdata,
  input  logic [NCTR-1:0] ovf,
  output ctrl_t           ctrl_q,
  output logic [NCTR-1:0] wr_pre,
  output logic [NCTR-1:0] pend_q,
  output logic            count_ok
);
  logic [NCTR-1:0] clr;
  logic            ctrl_hit;

  assign ctrl_hit = reg_wr && (addr_e'(reg_addr) == ADDR_CTRL);
  assign clr      = (reg_wr && addr_e'(reg_addr) == ADDR_PCLR) ? reg_wdata[NCTR-1:0] : '0;
  assign wr_pre[0] = reg_wr && (addr_e'(reg_addr) == ADDR_PRE0);
  assign wr_pre[1] = reg_wr && (addr_e'(reg_addr) == ADDR_PRE1);
  assign count_ok = (ctrl_q.sys_en || ctrl_q.proc_en) && !ctrl_q.mode_prof;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else if (ctrl_hit) ctrl_q <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else pend_q <= (pend_q & ~clr) | (ovf & ctrl_q.irq_en);
  end

  generate
    for (genvar i = 0; i < NCTR; i++) begin : g_pchk
      AST_PEND_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend_q[i] && !(ovf[i] && ctrl_q.irq_en[i])) |=> !pend_q[i]); // R7
      AST_SET_BEATS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr[i] && ovf[i] && ctrl_q.irq_en[i]) |=> pend_q[i]); // R8
      AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr[i] && !ovf[i]) |=> !pend_q[i]); // R8
    end
  endgenerate
endmodule

// File: rtl/pcnt_counter.sv
module pcnt_counter
  import pcnt_pkg::*;
#(
  parameter int unsigned INC_W = 4,
  parameter cnt_t        LIMIT = cnt_t'((1 << CW) - 16)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_hit,
  input  cnt_t             wr_val,
  input  logic             adv_en,
  input  logic [INC_W-1:0] inc,
  output cnt_t             cnt_q,
  output logic             ovf
);
  localparam cnt_t INC_CEIL = cnt_t'(1 << INC_W);

  logic [CW:0] sum;
  logic        adv;

  assign adv = adv_en && !wr_hit;
  assign sum = add_wide(cnt_q, cnt_t'(inc));
  assign ovf = adv && sum[CW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (wr_hit) cnt_q <= clamp_val(wr_val, LIMIT);
    else if (adv)    cnt_q <= sum[CW-1:0];
  end

  AST_PRELOAD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> cnt_q <= LIMIT); // R4
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_hit && !adv_en) |=> $stable(cnt_q)); // R2
  AST_WRAP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> cnt_q < INC_CEIL); // R6
endmodule

// File: rtl/perf_ctr_pair.sv
module perf_ctr_pair
  import pcnt_pkg::*;
#(
  parameter int unsigned INC0_W = 4,
  parameter int unsigned INC1_W = 2,
  parameter cnt_t        LIM0   = cnt_t'((1 << CW) - 16),
  parameter cnt_t        LIM1   = cnt_t'((1 << CW) - 4)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [CW-1:0]     reg_wdata,
  input  logic [INC0_W-1:0] evt0_inc,
  input  logic [INC1_W-1:0] evt1_inc,
  output logic [2*CW-1:0]   rd_ctrs,
  output logic [1:0]        pend,
  output logic              irq
);
  localparam int unsigned NCTR = 2;

  ctrl_t           ctrl_q;
  logic [NCTR-1:0] wr_pre;
  logic [NCTR-1:0] ovf;
  logic [NCTR-1:0] pend_q;
  logic            count_ok;
  cnt_t            ctr_q [NCTR];

  pcnt_ctrl #(.NCTR(NCTR)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .ovf(ovf), .ctrl_q(ctrl_q), .wr_pre(wr_pre),
    .pend_q(pend_q), .count_ok(count_ok)
  );

  generate
    for (genvar i = 0; i < NCTR; i++) begin : g_ctr
      if (i == 0) begin : g_c0
        pcnt_counter #(.INC_W(INC0_W), .LIMIT(LIM0)) u_cnt (
          .clk(clk), .rst_n(rst_n), .wr_hit(wr_pre[i]), .wr_val(reg_wdata),
          .adv_en(count_ok && ctrl_q.cnt_en[i]), .inc(evt0_inc),
          .cnt_q(ctr_q[i]), .ovf(ovf[i])
        );
      end else begin : g_c1
        pcnt_counter #(.INC_W(INC1_W), .LIMIT(LIM1)) u_cnt (
          .clk(clk), .rst_n(rst_n), .wr_hit(wr_pre[i]), .wr_val(reg_wdata),
          .adv_en(count_ok && ctrl_q.cnt_en[i]), .inc(evt1_inc),
          .cnt_q(ctr_q[i]), .ovf(ovf[i])
        );
      end
      AST_PROF_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.mode_prof && !wr_pre[i]) |=> $stable(ctr_q[i])); // R9
    end
  endgenerate

  assign rd_ctrs = {ctr_q[1], ctr_q[0]};
  assign pend    = pend_q;
  assign irq     = |pend_q;
endmodule

// File: tb/perf_ctr_pair_tb.sv
module perf_ctr_pair_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;
  // {wr, addr, data, inc0, inc1, exp0, exp1, exp_pend}
  localparam logic [70:0] VEC [NVEC] = '{
    {1'b1, 2'd0, 20'h0003D, 4'd5,  2'd1, 20'h00000, 20'h00000, 2'b00},
    {1'b1, 2'd1, 20'hFFFFF, 4'd3,  2'd2, 20'hFFFF0, 20'h00002, 2'b00},
    {1'b1, 2'd2, 20'hFFFFE, 4'd15, 2'd0, 20'hFFFFF, 20'hFFFFC, 2'b00},
    {1'b0, 2'd0, 20'h00000, 4'd1,  2'd3, 20'h00000, 20'hFFFFF, 2'b01},
    {1'b0, 2'd0, 20'h00000, 4'd0,  2'd1, 20'h00000, 20'h00000, 2'b11},
    {1'b1, 2'd3, 20'h00001, 4'd0,  2'd0, 20'h00000, 20'h00000, 2'b10}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [19:0] reg_wdata = '0;
  logic [3:0]  evt0_inc = '0;
  logic [1:0]  evt1_inc = '0;
  logic [39:0] rd_ctrs;
  logic [1:0]  pend;
  logic        irq;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  perf_ctr_pair dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .evt0_inc(evt0_inc), .evt1_inc(evt1_inc),
    .rd_ctrs(rd_ctrs), .pend(pend), .irq(irq)
  );

  task automatic check(string tag, logic [19:0] e0, logic [19:0] e1, logic [1:0] ep);
    checks++;
    if (rd_ctrs[19:0] !== e0 || rd_ctrs[39:20] !== e1 || pend !== ep || irq !== (|ep)) begin
      errors++;
      $display("FAIL %s: ctr0=%h ctr1=%h pend=%b irq=%b expected ctr0=%h ctr1=%h pend=%b irq=%b",
               tag, rd_ctrs[19:0], rd_ctrs[39:20], pend, irq, e0, e1, ep, |ep);
    end
  endtask

  task automatic cyc(logic wr, logic [1:0] a, logic [19:0] d, logic [3:0] i0, logic [1:0] i1,
                     logic [19:0] e0, logic [19:0] e1, logic [1:0] ep, string tag);
    @(negedge clk);
    reg_wr = wr; reg_addr = a; reg_wdata = d; evt0_inc = i0; evt1_inc = i1;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0; evt0_inc = '0; evt1_inc = '0;
    check(tag, e0, e1, ep);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset state", '0, '0, 2'b00);
    rst_n = 1'b1;
    // R3 R4 R5 R6 R7 R8 R10 table walk
    for (int k = 0; k < NVEC; k++) begin
      cyc(VEC[k][70], VEC[k][69:68], VEC[k][67:48], VEC[k][47:44], VEC[k][43:42],
          VEC[k][41:22], VEC[k][21:2], VEC[k][1:0], $sformatf("R5 R6 R7 R10 vector %0d", k));
    end
    // R8: clear both flags while counter 0 wraps in the same cycle
    cyc(1'b1, 2'd1, 20'hFFFFF, 4'd0,  2'd0, 20'hFFFF0, 20'h0, 2'b10, "R4 clamp preload 0");
    cyc(1'b0, 2'd0, 20'h0,     4'd15, 2'd0, 20'hFFFFF, 20'h0, 2'b10, "R2 count to top");
    cyc(1'b1, 2'd3, 20'h3,     4'd2,  2'd0, 20'h00001, 20'h0, 2'b01, "R8 clear vs overflow");
    cyc(1'b1, 2'd3, 20'h1,     4'd0,  2'd0, 20'h00001, 20'h0, 2'b00, "R8 clear remaining");
    // R7: mask off, overflow leaves no flag
    cyc(1'b1, 2'd0, 20'h0000D, 4'd0,  2'd0, 20'h00001, 20'h0, 2'b00, "R3 ctrl mask off");
    cyc(1'b1, 2'd2, 20'hFFFFC, 4'd0,  2'd0, 20'h00001, 20'hFFFFC, 2'b00, "R4 preload 1 ceiling");
    cyc(1'b0, 2'd0, 20'h0,     4'd0,  2'd3, 20'h00001, 20'hFFFFF, 2'b00, "R2 ctr1 advance");
    cyc(1'b0, 2'd0, 20'h0,     4'd0,  2'd1, 20'h00001, 20'h00000, 2'b00, "R7 masked overflow");
    // R9: sampling mode halts counting
    cyc(1'b1, 2'd0, 20'h0004D, 4'd2,  2'd0, 20'h00003, 20'h0, 2'b00, "R3 old ctrl still active");
    cyc(1'b0, 2'd0, 20'h0,     4'd5,  2'd3, 20'h00003, 20'h0, 2'b00, "R9 mode halts");
    // R2: global gates
    cyc(1'b1, 2'd0, 20'h0000C, 4'd0,  2'd0, 20'h00003, 20'h0, 2'b00, "R3 no global enable");
    cyc(1'b0, 2'd0, 20'h0,     4'd4,  2'd1, 20'h00003, 20'h0, 2'b00, "R2 no global enable holds");
    cyc(1'b1, 2'd0, 20'h0000E, 4'd0,  2'd0, 20'h00003, 20'h0, 2'b00, "R3 per-process enable");
    cyc(1'b0, 2'd0, 20'h0,     4'd4,  2'd1, 20'h00007, 20'h1, 2'b00, "R2 per-process counts");
    cyc(1'b1, 2'd0, 20'h00005, 4'd0,  2'd0, 20'h00007, 20'h1, 2'b00, "R3 only counter 0");
    cyc(1'b0, 2'd0, 20'h0,     4'd2,  2'd2, 20'h00009, 20'h1, 2'b00, "R2 counter 1 disabled");
    cyc(1'b1, 2'd1, 20'h12345, 4'd7,  2'd0, 20'h12345, 20'h1, 2'b00, "R4 R5 in-range preload");
    // R1: reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 reset clears", '0, '0, 2'b00);
    rst_n = 1'b1;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule